// File: doc/BRIEF.md
# Monochrome Bitmap Color Expander

This block converts one-bit-per-pixel source data into full-depth pixels for a rectangular screen area. Each source bit selects between a programmable foreground color (bit set) and a background color (bit clear). A rectangle is launched by a single start pulse that captures its origin, width, height, colors and mode. Pixels then leave the block in raster order, one per cycle at most, each tagged with its screen coordinate. Source data arrives as 32-bit words over a valid/ready handshake.

Two stream packings are supported. In row-padded mode every row begins on a fresh word. In packed mode rows follow each other bit for bit with no padding. A third and fourth mode draw a tiled pattern instead. The pattern rows are first loaded as words, and the pattern coordinate is then derived from the screen position modulo the pattern size. In the offset form that derivation starts from an explicit origin inside the pattern.

Top module: `mono_expand`

## Requirements
- R1: After reset, `pix_valid`, `done` and `in_ready` are all low.
- R2: A source bit of 1 yields `pix_color` = foreground; a bit of 0 yields background.
- R3: Within each input word, bit 31 is the first pixel and bit 0 the last.
- R4: Pixels appear in raster order: x runs from x0 to x0+w-1 for y = y0, then for y0+1, and so on up to y0+h-1.
- R5: In mode 0 (row-padded) each row starts at bit 31 of a new word. Any bits left in a word at the end of a row are dropped, so a rectangle takes h*ceil(w/32) words.
- R6: In mode 1 (packed), pixel n of the rectangle (n = y*w + x) uses word n/32, bit 31 - n%32, so a rectangle takes ceil(w*h/32) words.
- R7: Bits left in the last word after the final pixel are discarded, and the next rectangle starts with a new word.
- R8: `done` is high for exactly one cycle, the cycle after the last pixel, and never together with `pix_valid`.
- R9: In mode 2 (tiled fill), the block first takes ph words as pattern rows 0..ph-1. Within a row, column c is bit 31-c. Screen pixel (x, y) then uses pattern cell (x mod pw, y mod ph).
- R10: In mode 3 (tiled offset), pixel (x0+dx, y0+dy) uses pattern cell ((sx+dx) mod pw, (sy+dy) mod ph).
- R11: A start pulse while a rectangle is in progress is ignored, and the captured configuration does not change.
- R12: With input words always offered, a stream rectangle delivers one pixel in every cycle from its first pixel to its last, with no gap at word boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, captured only when idle |
| cfg_mode | input | 2 | 0 row-padded, 1 packed, 2 tiled fill, 3 tiled offset |
| cfg_fg | input | DEPTH | Foreground color |
| cfg_bg | input | DEPTH | Background color |
| cfg_x0 | input | COORD_W | Screen x origin |
| cfg_y0 | input | COORD_W | Screen y origin |
| cfg_w | input | DIM_W | Rectangle width (>= 1) |
| cfg_h | input | DIM_W | Rectangle height (>= 1) |
| cfg_pw | input | log2(WORD_W)+1 | Pattern width, 1..WORD_W |
| cfg_ph | input | log2(PAT_ROWS)+1 | Pattern height, 1..PAT_ROWS |
| cfg_sx | input | COORD_W | Pattern x origin for mode 3 |
| cfg_sy | input | COORD_W | Pattern y origin for mode 3 |
| in_valid | input | 1 | Source word offered |
| in_word | input | WORD_W | Source word |
| in_ready | output | 1 | Source word taken this cycle when valid |
| pix_valid | output | 1 | Pixel present |
| pix_x | output | COORD_W | Pixel screen x |
| pix_y | output | COORD_W | Pixel screen y |
| pix_color | output | DEPTH | Pixel color |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The assertions assume that width and height are at least one, and that in the tiled modes the pattern width lies in 1..32 and the height in 1..8. Without these limits the modulo and the end-of-row compare have no defined meaning. The configuration inputs only need to be valid on the cycle that carries the start pulse. The sweep keeps every rectangle and pattern size within these limits. It changes the configuration inputs only around the start pulse, except in one deliberate case that pulses start with altered values in the middle of a rectangle.

// File: rtl/mx_pkg.sv
package mx_pkg;
  typedef enum logic [1:0] {
    MODE_ROWPAD    = 2'd0,
    MODE_PACKED    = 2'd1,
    MODE_TILE_FILL = 2'd2,
    MODE_TILE_OFFS = 2'd3
  } mx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } mx_state_e;
endpackage

// File: rtl/mx_word_buf.sv
module mx_word_buf #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  input  logic              use_bit,
  input  logic              row_end,
  input  logic              rect_end,
  input  logic              take_word,
  output logic              full,
  output logic              cur_bit,
  output logic [WORD_W-1:0] cur_word
);
  localparam int IW = $clog2(WORD_W);

  logic [WORD_W-1:0] word_q;
  logic [IW-1:0]     idx_q, idx_d;
  logic              full_q, full_d;
  logic              drop, accept;

  // a word is freed once its last bit is used, at a padded row end,
  // at the rectangle end, or when taken whole as a pattern row
  assign drop     = take_word |
                    (use_bit & ((idx_q == IW'(WORD_W-1)) | row_end | rect_end));
  assign in_ready = allow & (~full_q | drop);
  assign accept   = in_valid & in_ready;

  always_comb begin
    full_d = full_q;
    idx_d  = idx_q;
    if (drop)               full_d = 1'b0;
    if (use_bit && !drop)   idx_d  = idx_q + 1'b1;
    if (accept) begin
      full_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      full_q <= full_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) word_q <= in_word;
  end

  assign full     = full_q;
  assign cur_word = word_q;
  assign cur_bit  = word_q[IW'(WORD_W-1) - idx_q];

  // R3: a bit is only consumed from a word that is present
  a_r3_bit_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    use_bit |-> full_q);
  // R12: an accepted word is present in the next cycle
  a_r12_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> full_q);
endmodule

// File: rtl/mx_raster.sv
module mx_raster #(
  parameter int DIM_W = 12,
  parameter int PXW   = 5,
  parameter int PYW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic [DIM_W-1:0] w,
  input  logic [DIM_W-1:0] h,
  input  logic [PXW:0]     pw,
  input  logic [PYW:0]     ph,
  input  logic [PXW-1:0]   px_init,
  input  logic [PYW-1:0]   py_init,
  output logic [DIM_W-1:0] cx,
  output logic [DIM_W-1:0] cy,
  output logic [PXW-1:0]   px,
  output logic [PYW-1:0]   py,
  output logic             row_last,
  output logic             rect_last
);
  logic [DIM_W-1:0] cx_q, cx_d, cy_q, cy_d;
  logic [PXW-1:0]   px_q, px_d, px0_q;
  logic [PYW-1:0]   py_q, py_d;
  logic             px_wrap, py_wrap;

  assign row_last  = (cx_q == w - 1'b1);
  assign rect_last = row_last && (cy_q == h - 1'b1);
  assign px_wrap   = ({1'b0, px_q} == pw - 1'b1);
  assign py_wrap   = ({1'b0, py_q} == ph - 1'b1);

  always_comb begin
    cx_d = cx_q;
    cy_d = cy_q;
    px_d = px_q;
    py_d = py_q;
    if (init) begin
      cx_d = '0;
      cy_d = '0;
      px_d = px_init;
      py_d = py_init;
    end else if (step) begin
      if (row_last) begin
        cx_d = '0;
        cy_d = cy_q + 1'b1;
        px_d = px0_q;
        py_d = py_wrap ? '0 : py_q + 1'b1;
      end else begin
        cx_d = cx_q + 1'b1;
        px_d = px_wrap ? '0 : px_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx_q <= '0;
      cy_q <= '0;
      px_q <= '0;
      py_q <= '0;
    end else begin
      cx_q <= cx_d;
      cy_q <= cy_d;
      px_q <= px_d;
      py_q <= py_d;
    end
  end

  always_ff @(posedge clk) begin
    if (init) px0_q <= px_init;
  end

  assign cx = cx_q;
  assign cy = cy_q;
  assign px = px_q;
  assign py = py_q;
endmodule

// File: rtl/mx_pattern_store.sv
module mx_pattern_store #(
  parameter int WORD_W = 32,
  parameter int ROWS   = 8
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [$clog2(ROWS)-1:0]   wr_row,
  input  logic [WORD_W-1:0]         wr_word,
  input  logic [$clog2(WORD_W)-1:0] rd_x,
  input  logic [$clog2(ROWS)-1:0]   rd_y,
  output logic                      rd_bit
);
  localparam int XW = $clog2(WORD_W);

  logic [WORD_W-1:0] rows_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (wr_en && (wr_row == r[$clog2(ROWS)-1:0])) rows_q[r] <= wr_word;
    end
  end

  assign rd_bit = rows_q[rd_y][XW'(WORD_W-1) - rd_x];
endmodule

// File: rtl/mono_expand.sv
module mono_expand
  import mx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int COORD_W  = 12,
  parameter int DIM_W    = 12,
  parameter int WORD_W   = 32,
  parameter int PAT_ROWS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [1:0]                    cfg_mode,
  input  logic [DEPTH-1:0]              cfg_fg,
  input  logic [DEPTH-1:0]              cfg_bg,
  input  logic [COORD_W-1:0]            cfg_x0,
  input  logic [COORD_W-1:0]            cfg_y0,
  input  logic [DIM_W-1:0]              cfg_w,
  input  logic [DIM_W-1:0]              cfg_h,
  input  logic [$clog2(WORD_W):0]       cfg_pw,
  input  logic [$clog2(PAT_ROWS):0]     cfg_ph,
  input  logic [COORD_W-1:0]            cfg_sx,
  input  logic [COORD_W-1:0]            cfg_sy,
  input  logic                          in_valid,
  input  logic [WORD_W-1:0]             in_word,
  output logic                          in_ready,
  output logic                          pix_valid,
  output logic [COORD_W-1:0]            pix_x,
  output logic [COORD_W-1:0]            pix_y,
  output logic [DEPTH-1:0]              pix_color,
  output logic                          done
);
  localparam int PXW = $clog2(WORD_W);
  localparam int PYW = $clog2(PAT_ROWS);
  localparam int PWW = PXW + 1;
  localparam int PHW = PYW + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  mx_state_e        state_q, state_d;
  logic [PYW-1:0]   ld_q, ld_d;
  mx_mode_e         mode_q;
  logic [DEPTH-1:0] fg_q, bg_q;
  logic [COORD_W-1:0] x0_q, y0_q;
  logic [DIM_W-1:0] w_q, h_q;
  logic [PWW-1:0]   pw_q;
  logic [PHW-1:0]   ph_q;

  logic launch, is_tile, step, use_bit, take_word, allow;
  logic buf_full, buf_bit, pat_bit, src_bit;
  logic [WORD_W-1:0] buf_word;
  logic row_last, rect_last;
  logic [DIM_W-1:0] cx, cy;
  logic [PXW-1:0] pat_x, px_calc;
  logic [PYW-1:0] pat_y, py_calc;
  logic [COORD_W-1:0] base_x, base_y;

  assign launch = start && (state_q == ST_IDLE);
  assign is_tile = mode_q[1];

  // starting pattern cell: screen origin in fill mode, explicit origin in offset mode
  assign base_x  = (cfg_mode == MODE_TILE_OFFS) ? cfg_sx : cfg_x0;
  assign base_y  = (cfg_mode == MODE_TILE_OFFS) ? cfg_sy : cfg_y0;
  assign px_calc = PXW'(base_x % COORD_W'(cfg_pw));
  assign py_calc = PYW'(base_y % COORD_W'(cfg_ph));

  // configuration capture, clock-enabled by launch only
  always_ff @(posedge clk) begin
    if (launch) begin
      mode_q <= mx_mode_e'(cfg_mode);
      fg_q   <= cfg_fg;
      bg_q   <= cfg_bg;
      x0_q   <= cfg_x0;
      y0_q   <= cfg_y0;
      w_q    <= cfg_w;
      h_q    <= cfg_h;
      pw_q   <= cfg_pw;
      ph_q   <= cfg_ph;
    end
  end

  assign step      = (state_q == ST_RUN) && (is_tile || buf_full);
  assign use_bit   = step && !is_tile;
  assign take_word = (state_q == ST_LOAD) && buf_full;
  assign allow     = (state_q == ST_LOAD) || ((state_q == ST_RUN) && !is_tile);

  always_comb begin
    state_d = state_q;
    ld_d    = ld_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        ld_d    = '0;
        state_d = cfg_mode[1] ? ST_LOAD : ST_RUN;
      end
      ST_LOAD: if (buf_full) begin
        ld_d = ld_q + 1'b1;
        if ({1'b0, ld_q} == ph_q - 1'b1) state_d = ST_RUN;
      end
      ST_RUN: if (step && rect_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      ld_q    <= '0;
    end else begin
      state_q <= state_d;
      ld_q    <= ld_d;
    end
  end

  mx_word_buf #(.WORD_W(WORD_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_q),
    .allow    (allow),
    .in_valid (in_valid),
    .in_word  (in_word),
    .in_ready (in_ready),
    .use_bit  (use_bit),
    .row_end  ((mode_q == MODE_ROWPAD) && row_last),
    .rect_end (rect_last),
    .take_word(take_word),
    .full     (buf_full),
    .cur_bit  (buf_bit),
    .cur_word (buf_word)
  );

  mx_raster #(.DIM_W(DIM_W), .PXW(PXW), .PYW(PYW)) u_ras (
    .clk      (clk),
    .rst_n    (rst_q),
    .init     (launch),
    .step     (step),
    .w        (w_q),
    .h        (h_q),
    .pw       (pw_q),
    .ph       (ph_q),
    .px_init  (px_calc),
    .py_init  (py_calc),
    .cx       (cx),
    .cy       (cy),
    .px       (pat_x),
    .py       (pat_y),
    .row_last (row_last),
    .rect_last(rect_last)
  );

  mx_pattern_store #(.WORD_W(WORD_W), .ROWS(PAT_ROWS)) u_pat (
    .clk    (clk),
    .wr_en  (take_word),
    .wr_row (ld_q),
    .wr_word(buf_word),
    .rd_x   (pat_x),
    .rd_y   (pat_y),
    .rd_bit (pat_bit)
  );

  assign src_bit = is_tile ? pat_bit : buf_bit;

  // output stage
  logic pv_q, last_q, done_q;
  logic [COORD_W-1:0] x_q, y_q;
  logic [DEPTH-1:0] col_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pv_q   <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pv_q   <= step;
      last_q <= step && rect_last;
      done_q <= last_q;
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      x_q   <= x0_q + COORD_W'(cx);
      y_q   <= y0_q + COORD_W'(cy);
      col_q <= src_bit ? fg_q : bg_q;
    end
  end

  assign pix_valid = pv_q;
  assign pix_x     = x_q;
  assign pix_y     = y_q;
  assign pix_color = col_q;
  assign done      = done_q;

  // R8: completion follows a pixel and never coincides with one
  a_r8_done_after_pixel: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |-> $past(pv_q));
  a_r8_done_alone: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |-> !pv_q);
  // R4: emitted coordinates stay inside the captured rectangle
  a_r4_x_inside: assert property (@(posedge clk) disable iff (!rst_q)
    pv_q |-> (COORD_W'(x_q - x0_q) < COORD_W'(w_q)));
  a_r4_y_inside: assert property (@(posedge clk) disable iff (!rst_q)
    pv_q |-> (COORD_W'(y_q - y0_q) < COORD_W'(h_q)));
  // R11: configuration is frozen while a rectangle is in progress
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q != ST_IDLE) |=> ($stable(w_q) && $stable(fg_q) && $stable(mode_q)));
  // R9: pattern column stays below the pattern width
  a_r9_pat_col: assert property (@(posedge clk) disable iff (!rst_q)
    ((state_q == ST_RUN) && is_tile) |-> ({1'b0, pat_x} < pw_q));
endmodule

// File: tb/sim_mono_expand.sv
`timescale 1ns/1ps
module sim_mono_expand;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  cfg_mode;
  logic [7:0]  cfg_fg, cfg_bg;
  logic [11:0] cfg_x0, cfg_y0, cfg_w, cfg_h, cfg_sx, cfg_sy;
  logic [5:0]  cfg_pw;
  logic [3:0]  cfg_ph;
  logic        in_valid;
  logic [31:0] in_word;
  logic        in_ready, pix_valid, done;
  logic [11:0] pix_x, pix_y;
  logic [7:0]  pix_color;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  logic [31:0] wmem [128];

  always #10 clk = ~clk;

  mono_expand u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_fg(cfg_fg), .cfg_bg(cfg_bg), .cfg_x0(cfg_x0), .cfg_y0(cfg_y0),
    .cfg_w(cfg_w), .cfg_h(cfg_h), .cfg_pw(cfg_pw), .cfg_ph(cfg_ph),
    .cfg_sx(cfg_sx), .cfg_sy(cfg_sy), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .pix_color(pix_color), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_bit(int mode, int dx, int dy, int w, int x0, int y0,
                                 int pw, int ph, int sx, int sy);
    int n, wi, bi;
    case (mode)
      0: begin wi = dy * ((w + 31) / 32) + dx / 32; bi = 31 - dx % 32; end
      1: begin n = dy * w + dx; wi = n / 32; bi = 31 - n % 32; end
      default: begin
        wi = ((mode == 3 ? sy : y0) + dy) % ph;
        bi = 31 - ((mode == 3 ? sx : x0) + dx) % pw;
      end
    endcase
    return wmem[wi][bi];
  endfunction

  task automatic run_rect(input int mode, input int x0, input int y0, input int w, input int h,
                          input int pw, input int ph, input int sx, input int sy,
                          input int seed, input bit gaps, input bit glitch);
    int nw, idx, k, first, dx, dy;
    bit fire, got_done, e;
    logic [7:0] fg, bg, ec;
    fg = 8'(seed * 37 + 5);
    bg = ~fg;
    for (int i = 0; i < 128; i++) wmem[i] = (32'(i + seed) * 32'h9E3779B1) ^ (32'(seed) << 9) ^ 32'h5A3C_0F96;
    case (mode)
      0: nw = h * ((w + 31) / 32);
      1: nw = (w * h + 31) / 32;
      default: nw = ph;
    endcase
    idx = 0; k = 0; first = 0; got_done = 0;
    for (int cyc = 0; cyc < 4000 && !got_done; cyc++) begin
      @(negedge clk);
      start = (cyc == 0) || (glitch && cyc == 6);
      if (cyc == 0 || (glitch && cyc == 7)) begin
        cfg_mode = 2'(mode); cfg_fg = fg; cfg_bg = bg;
        cfg_x0 = 12'(x0); cfg_y0 = 12'(y0); cfg_w = 12'(w); cfg_h = 12'(h);
        cfg_pw = 6'(pw); cfg_ph = 4'(ph); cfg_sx = 12'(sx); cfg_sy = 12'(sy);
      end
      if (glitch && cyc == 6) begin
        cfg_fg = ~fg; cfg_w = 12'(w + 3); cfg_mode = 2'((mode + 1) % 2);
      end
      if (pix_valid) begin
        dx = k % w; dy = k / w;
        e = exp_bit(mode, dx, dy, w, x0, y0, pw, ph, sx, sy);
        ec = e ? fg : bg;
        if (k == 0) first = cyc;
        // R4 raster coordinates; R2/R3/R5/R6/R9/R10 color from source bit
        chk(pix_x == 12'(x0 + dx), "R4 pix_x", 32'(pix_x), 32'(x0 + dx));
        chk(pix_y == 12'(y0 + dy), "R4 pix_y", 32'(pix_y), 32'(y0 + dy));
        case (mode)
          0: chk(pix_color == ec, "R2 R3 R5 padded color", 32'(pix_color), 32'(ec));
          1: chk(pix_color == ec, "R2 R3 R6 packed color", 32'(pix_color), 32'(ec));
          2: chk(pix_color == ec, "R9 tiled fill color", 32'(pix_color), 32'(ec));
          default: chk(pix_color == ec, "R10 tiled offset color", 32'(pix_color), 32'(ec));
        endcase
        chk(!done, "R8 done with pixel", 32'(done), 0);
        k++;
      end
      if (done) begin
        got_done = 1;
        chk(k == w * h, "R8 pixel count at done", 32'(k), 32'(w * h));
        chk(idx == nw, "R5 R6 R7 R9 words consumed", 32'(idx), 32'(nw));
        if (!gaps && mode < 2)
          chk(cyc - first == w * h, "R12 no bubbles", 32'(cyc - first), 32'(w * h));
        if (glitch)
          chk(k == w * h, "R11 start ignored while busy", 32'(k), 32'(w * h));
      end
      in_valid = (idx < nw) && !(gaps && (cyc % 3 == 1)) && !got_done;
      in_word  = in_valid ? wmem[idx] : 32'h0;
      fire = in_valid && in_ready;
      @(posedge clk);
      if (fire) idx++;
    end
    if (!got_done) chk(0, "R8 done never seen", 0, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!done && !pix_valid, "R8 single done pulse", 32'({done, pix_valid}), 0);
    chk(!in_ready, "R7 no word taken when idle", 32'(in_ready), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_word = '0;
    cfg_mode = '0; cfg_fg = '0; cfg_bg = '0; cfg_x0 = '0; cfg_y0 = '0;
    cfg_w = 12'd1; cfg_h = 12'd1; cfg_pw = 6'd1; cfg_ph = 4'd1; cfg_sx = '0; cfg_sy = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!pix_valid, "R1 pix_valid after reset", 32'(pix_valid), 0);
    chk(!done, "R1 done after reset", 32'(done), 0);
    chk(!in_ready, "R1 in_ready after reset", 32'(in_ready), 0);
    // stream modes: widths around word boundaries, several heights
    for (int m = 0; m < 2; m++)
      foreach (wmem[i]) if (i < 6) begin
        int wl [6] = '{1, 5, 31, 32, 33, 70};
        for (int h = 1; h <= 4; h += 3)
          run_rect(m, 3 + i, 2 * h, wl[i], h, 1, 1, 0, 0, 11 * i + h + 50 * m, 1'b0, 1'b0);
      end
    // R7: back-to-back rectangles with leftover bits, and stalled input
    run_rect(1, 0, 0, 7, 3, 1, 1, 0, 0, 3, 1'b1, 1'b0);
    run_rect(0, 9, 9, 40, 2, 1, 1, 0, 0, 4, 1'b1, 1'b0);
    run_rect(1, 100, 7, 13, 5, 1, 1, 0, 0, 8, 1'b1, 1'b0);
    // R11 start while busy
    run_rect(0, 20, 30, 33, 3, 1, 1, 0, 0, 77, 1'b0, 1'b1);
    // R9 tiled fill sweep over pattern sizes
    foreach (wmem[a]) if (a < 4) begin
      int pwl [4] = '{1, 3, 8, 32};
      for (int ph = 1; ph <= 8; ph++)
        if (ph == 1 || ph == 2 || ph == 5 || ph == 8)
          run_rect(2, 13 + a, 6 + ph, 9, 7, pwl[a], ph, 0, 0, 200 + 9 * a + ph, 1'b0, 1'b0);
    end
    // R10 tiled offset with explicit pattern origin
    run_rect(3, 40, 50, 10, 6, 5, 3, 2, 1, 301, 1'b0, 1'b0);
    run_rect(3, 7, 0, 35, 4, 32, 8, 30, 7, 302, 1'b1, 1'b0);
    run_rect(3, 0, 0, 6, 9, 4, 8, 13, 11, 303, 1'b0, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule